// File: doc/BRIEF.md
# Minor-Loop Mover with Bus-Error Termination

This block moves one minor loop of a single DMA channel. After an accepted start pulse it runs alternating read and write bus cycles over a request/acknowledge/error bus. Each unit of the programmed transfer size is read from the source address and then written to the destination address. Every acknowledged read moves the source address by a signed offset. Every acknowledged write moves the destination address by its own signed offset and reduces the remaining byte count by the unit size. When the count reaches zero the loop ends and the engine presents the final source address, destination address and remaining count for writeback to the channel descriptor.

A bus cycle that ends with an error stops the transfer and sets a flag for the side that failed. What happens next depends on where the error occurred. A failed read still lets its paired write run, using the data returned with the error. A failed write still lets the next read run. The channel then stops. In both cases the writeback reports the addresses and count at the point of the fault, because a failed beat advances nothing. The done indication and both flags stay set until the next start is accepted.

The controller is a five-state machine:
- `ST_IDLE` is the state after reset.
- `ST_READ` issues one read bus cycle.
- `ST_WRITE` issues one write bus cycle.
- `ST_WRITEBACK` is a one-cycle descriptor update strobe.
- `ST_DONE` holds the result.

The transitions are:
- IDLE/DONE → READ when a start pulse arrives with a nonzero count.
- IDLE/DONE → WRITEBACK when a start pulse arrives with a zero count.
- READ → WRITE on a read response.
- READ → WRITEBACK on the response to the extra read that follows a write error.
- WRITE → READ after a good write that leaves a nonzero count.
- WRITE → READ after the first write error.
- WRITE → WRITEBACK when a good write empties the count.
- WRITE → WRITEBACK on any write response that follows a read error.
- WRITEBACK → DONE unconditionally.

Top module: `minor_loop_mover`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, bus_req, busy, done, wb_valid, src_err, dst_err and wb_count are all 0.
- R2: A start pulse is accepted only in IDLE or DONE. When accepted, it loads the configuration, and the first read request appears in the very next cycle. A start pulse while busy is 1 has no effect on the bus cycles or on the writeback values.
- R3: Each transfer unit is a read (bus_we=0) at the current source address followed by a write (bus_we=1) at the current destination address. The write data equals the bus_rdata returned with the preceding read. bus_size equals cfg_size_lg, and the unit is 2^cfg_size_lg bytes.
- R4: An acknowledged read adds the sign-extended cfg_src_off to the source address. An acknowledged write adds the sign-extended cfg_dst_off to the destination address and subtracts the unit size from the count, saturating at 0. The loop ends after the write that brings the count to 0. A start with cfg_nbytes=0 issues no bus cycle.
- R5: A beat that ends with bus_err=1 advances neither its address nor the count, even if bus_ack is also 1. The error takes priority.
- R6: A read error sets src_err. The write of the same unit is still issued with the data returned by the failed read, and then the channel stops.
- R7: A write error sets dst_err. One more read is then issued at the current source address, and then the channel stops. If that read also fails, src_err is set as well.
- R8: wb_valid is high for exactly one cycle, in the cycle after the final bus response (or after the accepted start when the count is zero). While it is high, wb_src, wb_dst and wb_count carry the final source address, destination address and remaining count.
- R9: done rises in the cycle after wb_valid. done, src_err and dst_err then hold until the next accepted start, which clears all three.
- R10: busy is 1 from the cycle after an accepted start through the writeback cycle, and done is 0 during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse for one minor loop |
| cfg_src | input | AW | Initial source address |
| cfg_dst | input | AW | Initial destination address |
| cfg_src_off | input | OW | Signed source offset per read |
| cfg_dst_off | input | OW | Signed destination offset per write |
| cfg_nbytes | input | CW | Bytes to move in this minor loop |
| cfg_size_lg | input | 2 | log2 of the transfer unit in bytes |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus cycle address |
| bus_size | output | 2 | log2 of the bus cycle size |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack or bus_err |
| bus_ack | input | 1 | Bus cycle completed |
| bus_err | input | 1 | Bus cycle terminated with error |
| busy | output | 1 | Loop in progress |
| done | output | 1 | Loop finished, held until next start |
| src_err | output | 1 | Source (read) bus-error flag |
| dst_err | output | 1 | Destination (write) bus-error flag |
| wb_valid | output | 1 | One-cycle descriptor writeback strobe |
| wb_src | output | AW | Source address for writeback |
| wb_dst | output | AW | Destination address for writeback |
| wb_count | output | CW | Remaining byte count for writeback |

## Verification
Once a start is accepted at a rising edge, the first read request is visible throughout the next cycle. Each bus response is committed at the edge that ends its cycle, so the next beat or the writeback strobe appears in the cycle that follows. done rises one cycle after wb_valid. The bench's bus responder records the cycle number of every response it gives, and of every accepted start. It then checks that wb_valid arrives exactly one cycle later and that the first request appears exactly one cycle after the start. All signals are sampled at the falling edge, where inputs are also driven, so each comparison lands in the cycle in which that result is due.

// File: rtl/mlm_pkg.sv
package mlm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_READ      = 3'd1,
        ST_WRITE     = 3'd2,
        ST_WRITEBACK = 3'd3,
        ST_DONE      = 3'd4
    } mlm_state_e;

    // Bytes in one transfer unit for a given log2 size code.
    function automatic logic [3:0] unit_bytes(input logic [1:0] size_lg);
        return 4'd1 << size_lg;
    endfunction

endpackage

// File: rtl/mlm_addr_walker.sv
module mlm_addr_walker #(
    parameter int AW = 32,
    parameter int OW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [OW-1:0] offset,
    input  logic          beat_done,
    input  logic          beat_err,
    output logic [AW-1:0] addr_q
);
    logic [OW-1:0] off_q;
    logic [AW-1:0] off_ext;

    generate
        if (AW > OW) begin : g_sext
            assign off_ext = {{(AW-OW){off_q[OW-1]}}, off_q};
        end else begin : g_trunc
            assign off_ext = off_q[AW-1:0];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            off_q  <= '0;
        end else if (load) begin
            addr_q <= base;
            off_q  <= offset;
        end else if (beat_done && !beat_err) begin
            addr_q <= addr_q + off_ext;
        end
    end

    // A failed beat leaves the address at the faulting location.
    assert_err_hold_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_done && beat_err && !load) |=> (addr_q == $past(addr_q)));

endmodule

// File: rtl/mlm_count_unit.sv
module mlm_count_unit
    import mlm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] nbytes,
    input  logic [1:0]    size_lg,
    input  logic          wr_done,
    input  logic          wr_err,
    output logic [CW-1:0] cnt_q,
    output logic [1:0]    size_lg_q,
    output logic          cnt_last
);
    logic [CW-1:0] step;

    assign step     = CW'(unit_bytes(size_lg_q));
    assign cnt_last = (cnt_q <= step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            size_lg_q <= '0;
        end else if (load) begin
            cnt_q     <= nbytes;
            size_lg_q <= size_lg;
        end else if (wr_done && !wr_err) begin
            cnt_q <= cnt_last ? '0 : (cnt_q - step);
        end
    end

    // Between loads the remaining count never grows.
    assert_cnt_nonincr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt_q <= $past(cnt_q)));

    // A failed write leaves the count unchanged.
    assert_err_hold_cnt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && wr_err && !load) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/mlm_err_flags.sv
module mlm_err_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic rd_done,
    input  logic wr_done,
    input  logic bus_err,
    output logic src_err,
    output logic dst_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_err <= 1'b0;
            dst_err <= 1'b0;
        end else if (clear) begin
            src_err <= 1'b0;
            dst_err <= 1'b0;
        end else begin
            if (rd_done && bus_err) src_err <= 1'b1;
            if (wr_done && bus_err) dst_err <= 1'b1;
        end
    end

    assert_src_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (src_err && !clear) |=> src_err);

    assert_dst_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_err && !clear) |=> dst_err);

endmodule

// File: rtl/mlm_fsm.sv
module mlm_fsm
    import mlm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cfg_zero,
    input  logic bus_ack,
    input  logic bus_err,
    input  logic cnt_last,
    input  logic src_err,
    input  logic dst_err,
    output logic load,
    output logic rd_done,
    output logic wr_done,
    output logic bus_req,
    output logic bus_we,
    output logic busy,
    output logic done,
    output logic wb_valid
);
    mlm_state_e state_q, state_d;
    logic       resp;

    assign resp = bus_ack | bus_err;
    assign load = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start) state_d = cfg_zero ? ST_WRITEBACK : ST_READ;
            end
            ST_READ: begin
                if (resp) state_d = dst_err ? ST_WRITEBACK : ST_WRITE;
            end
            ST_WRITE: begin
                if (resp) begin
                    if (bus_err)
                        state_d = src_err ? ST_WRITEBACK : ST_READ;
                    else
                        state_d = (src_err || cnt_last) ? ST_WRITEBACK : ST_READ;
                end
            end
            ST_WRITEBACK: state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Moore outputs plus beat-completion strobes
    always_comb begin
        bus_req  = 1'b0;
        bus_we   = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        wb_valid = 1'b0;
        rd_done  = 1'b0;
        wr_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_READ: begin
                bus_req = 1'b1;
                busy    = 1'b1;
                rd_done = resp;
            end
            ST_WRITE: begin
                bus_req = 1'b1;
                bus_we  = 1'b1;
                busy    = 1'b1;
                wr_done = resp;
            end
            ST_WRITEBACK: begin
                busy     = 1'b1;
                wb_valid = 1'b1;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    assert_wb_then_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> done);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_wb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |=> !wb_valid);

    assert_rd_err_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && bus_err && !dst_err) |=> (state_q == ST_WRITE));

    assert_deferred_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ && resp && dst_err) |=> (state_q == ST_WRITEBACK));

    assert_start_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> busy);

endmodule

// File: rtl/minor_loop_mover.sv
module minor_loop_mover #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int OW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] cfg_src,
    input  logic [AW-1:0] cfg_dst,
    input  logic [OW-1:0] cfg_src_off,
    input  logic [OW-1:0] cfg_dst_off,
    input  logic [CW-1:0] cfg_nbytes,
    input  logic [1:0]    cfg_size_lg,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [1:0]    bus_size,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    input  logic          bus_err,
    output logic          busy,
    output logic          done,
    output logic          src_err,
    output logic          dst_err,
    output logic          wb_valid,
    output logic [AW-1:0] wb_src,
    output logic [AW-1:0] wb_dst,
    output logic [CW-1:0] wb_count
);
    logic          load, rd_done, wr_done, cnt_last;
    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]    size_lg_q;
    logic [DW-1:0] data_q;

    mlm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cfg_zero (cfg_nbytes == '0),
        .bus_ack  (bus_ack),
        .bus_err  (bus_err),
        .cnt_last (cnt_last),
        .src_err  (src_err),
        .dst_err  (dst_err),
        .load     (load),
        .rd_done  (rd_done),
        .wr_done  (wr_done),
        .bus_req  (bus_req),
        .bus_we   (bus_we),
        .busy     (busy),
        .done     (done),
        .wb_valid (wb_valid)
    );

    mlm_addr_walker #(.AW(AW), .OW(OW)) u_src_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (cfg_src),
        .offset    (cfg_src_off),
        .beat_done (rd_done),
        .beat_err  (bus_err),
        .addr_q    (src_q)
    );

    mlm_addr_walker #(.AW(AW), .OW(OW)) u_dst_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .base      (cfg_dst),
        .offset    (cfg_dst_off),
        .beat_done (wr_done),
        .beat_err  (bus_err),
        .addr_q    (dst_q)
    );

    mlm_count_unit #(.CW(CW)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .nbytes    (cfg_nbytes),
        .size_lg   (cfg_size_lg),
        .wr_done   (wr_done),
        .wr_err    (bus_err),
        .cnt_q     (cnt_q),
        .size_lg_q (size_lg_q),
        .cnt_last  (cnt_last)
    );

    mlm_err_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .rd_done (rd_done),
        .wr_done (wr_done),
        .bus_err (bus_err),
        .src_err (src_err),
        .dst_err (dst_err)
    );

    // Read data is kept even on an errored read; the paired write uses it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       data_q <= '0;
        else if (rd_done) data_q <= bus_rdata;
    end

    assign bus_addr  = bus_we ? dst_q : src_q;
    assign bus_size  = size_lg_q;
    assign bus_wdata = data_q;
    assign wb_src    = src_q;
    assign wb_dst    = dst_q;
    assign wb_count  = cnt_q;

    // The write that follows a read carries that read's data.
    assert_wdata_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !dst_err) |=> (bus_wdata == $past(bus_rdata)));

endmodule

// File: tb/minor_loop_mover_test.sv
module minor_loop_mover_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] cfg_src = '0, cfg_dst = '0;
    logic [15:0] cfg_src_off = '0, cfg_dst_off = '0, cfg_nbytes = '0;
    logic [1:0]  cfg_size_lg = '0;
    logic        bus_req, bus_we;
    logic [31:0] bus_addr, bus_wdata;
    logic [1:0]  bus_size;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0, bus_err = 1'b0;
    logic        busy, done, src_err, dst_err, wb_valid;
    logic [31:0] wb_src, wb_dst;
    logic [15:0] wb_count;

    minor_loop_mover uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst),
        .cfg_src_off(cfg_src_off), .cfg_dst_off(cfg_dst_off),
        .cfg_nbytes(cfg_nbytes), .cfg_size_lg(cfg_size_lg),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err),
        .busy(busy), .done(done), .src_err(src_err), .dst_err(dst_err),
        .wb_valid(wb_valid), .wb_src(wb_src), .wb_dst(wb_dst), .wb_count(wb_count)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0, fails = 0;

    // Expected bus beats and writeback result
    bit          q_we[$];
    logic [31:0] q_addr[$];
    logic [31:0] q_data[$];
    logic [31:0] exp_src, exp_dst;
    logic [15:0] exp_cnt;
    bit          exp_serr, exp_derr;
    logic [1:0]  exp_size;
    string       wb_tag;

    // Responder settings and bookkeeping
    int     rd_err_at = -1, wr_err_at = -1, waits = 0;
    bit     err_ack = 0;
    int     run_id = 0, seen_id = 0;
    longint start_cyc = 0;
    bit     first_req_exp = 0;
    int     rd_n = 0, wr_n = 0, wcnt = 0, wb_seen = 0;
    longint last_evt = 0;
    bit     first_pend = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%08h expected=0x%08h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: list of beats and final descriptor values.
    task automatic build_expect(input logic [31:0] src, input logic [31:0] dst,
                                input int soff, input int doff, input int n,
                                input int lg, input int rerr, input int werr);
        logic [31:0] s, d;
        int c, sz;
        bit es, ed;
        q_we.delete(); q_addr.delete(); q_data.delete();
        s = src; d = dst; c = n; sz = 1 << lg; es = 0; ed = 0;
        if (c != 0) begin
            for (int i = 0; i < 4096; i++) begin
                logic [31:0] ra;
                ra = s;
                q_we.push_back(0); q_addr.push_back(s); q_data.push_back('0);
                if (i == rerr) es = 1; else s = s + soff;
                q_we.push_back(1); q_addr.push_back(d); q_data.push_back(pat(ra));
                if (i == werr) ed = 1;
                else begin
                    d = d + doff;
                    c = (c > sz) ? c - sz : 0;
                end
                if (es) break;
                if (ed) begin
                    q_we.push_back(0); q_addr.push_back(s); q_data.push_back('0);
                    if (i + 1 == rerr) es = 1; else s = s + soff;
                    break;
                end
                if (c == 0) break;
            end
        end
        exp_src = s; exp_dst = d; exp_cnt = c[15:0];
        exp_serr = es; exp_derr = ed; exp_size = lg[1:0];
    endtask

    // One falling-edge step of the bus responder and beat checker.
    task automatic responder_step();
        bit e;
        bus_ack = 1'b0;
        bus_err = 1'b0;
        if (run_id != seen_id) begin
            seen_id = run_id;
            rd_n = 0; wr_n = 0; wcnt = 0; wb_seen = 0;
            last_evt = start_cyc;
            first_pend = first_req_exp;
        end
        if (rst_n && bus_req) begin
            if (first_pend) begin
                check(cyc == start_cyc + 1, "R2", "first read cycle",
                      32'(cyc), 32'(start_cyc + 1));
                first_pend = 0;
            end
            if (wcnt < waits) wcnt++;
            else begin
                wcnt = 0;
                if (q_we.size() == 0) begin
                    check(0, "R3", "unexpected beat addr", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    bit          xw;
                    logic [31:0] xa, xd;
                    xw = q_we.pop_front(); xa = q_addr.pop_front(); xd = q_data.pop_front();
                    check(bus_we == xw, "R3", "beat direction", 32'(bus_we), 32'(xw));
                    check(bus_addr == xa, "R3", "beat address", bus_addr, xa);
                    check(bus_size == exp_size, "R3", "bus size", 32'(bus_size), 32'(exp_size));
                    if (xw) check(bus_wdata == xd, "R3", "write data", bus_wdata, xd);
                end
                if (bus_we) begin e = (wr_n == wr_err_at); wr_n++; end
                else begin e = (rd_n == rd_err_at); rd_n++; end
                bus_rdata = pat(bus_addr);
                bus_err = e;
                bus_ack = !e || err_ack;
                last_evt = cyc;
            end
        end
        if (rst_n && wb_valid) begin
            wb_seen++;
            check(cyc == last_evt + 1, "R8", "writeback cycle", 32'(cyc), 32'(last_evt + 1));
            check(wb_src == exp_src, wb_tag, "wb_src", wb_src, exp_src);
            check(wb_dst == exp_dst, wb_tag, "wb_dst", wb_dst, exp_dst);
            check(wb_count == exp_cnt, wb_tag, "wb_count", 32'(wb_count), 32'(exp_cnt));
        end
    endtask

    task automatic run_case(input logic [31:0] src, input logic [31:0] dst,
                            input int soff, input int doff, input int n, input int lg,
                            input int rerr, input int werr, input bit both,
                            input int w, input bit poke, input string tag);
        int t;
        build_expect(src, dst, soff, doff, n, lg, rerr, werr);
        wb_tag = tag;
        @(negedge clk);
        rd_err_at = rerr; wr_err_at = werr; err_ack = both; waits = w;
        cfg_src = src; cfg_dst = dst;
        cfg_src_off = soff[15:0]; cfg_dst_off = doff[15:0];
        cfg_nbytes = n[15:0]; cfg_size_lg = lg[1:0];
        start_cyc = cyc;
        first_req_exp = (n != 0);
        run_id++;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R10", "busy after start", 32'(busy), 32'd1);
        check(done == 1'b0, "R10", "done low while busy", 32'(done), 32'd0);
        check(src_err == 1'b0 && dst_err == 1'b0, "R9", "flags cleared by start",
              {30'd0, src_err, dst_err}, 32'd0);
        if (poke) begin
            repeat (3) @(negedge clk);
            check(busy == 1'b1, "R2", "still busy before stray start", 32'(busy), 32'd1);
            cfg_src = 32'hDEAD_0000; cfg_dst = 32'hBEEF_0000; cfg_nbytes = 16'd1;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done == 1'b1, "R9", "done reached", 32'(done), 32'd1);
        check(wb_seen == 1, "R8", "writeback strobes", 32'(wb_seen), 32'd1);
        check(q_we.size() == 0, "R3", "beats left over", 32'(q_we.size()), 32'd0);
        check(src_err == exp_serr, (rerr >= 0) ? "R6" : "R7", "src_err",
              32'(src_err), 32'(exp_serr));
        check(dst_err == exp_derr, "R7", "dst_err", 32'(dst_err), 32'(exp_derr));
        repeat (3) @(negedge clk);
        check(done == 1'b1 && busy == 1'b0 && bus_req == 1'b0 && wb_valid == 1'b0, "R9",
              "done held and idle", {28'd0, done, busy, bus_req, wb_valid}, 32'h8);
        check(src_err == exp_serr && dst_err == exp_derr, "R9", "flags held",
              {30'd0, src_err, dst_err}, {30'd0, exp_serr, exp_derr});
    endtask

    initial begin
        fork
            forever begin
                @(negedge clk);
                responder_step();
            end
            begin
                wait (cyc > WATCHDOG);
                fails++;
                $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
                $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check({bus_req, busy, done, wb_valid, src_err, dst_err} == 6'd0, "R1",
              "outputs in reset", {26'd0, bus_req, busy, done, wb_valid, src_err, dst_err}, 32'd0);
        check(wb_count == 16'd0, "R1", "count in reset", 32'(wb_count), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check({bus_req, busy, done, wb_valid, src_err, dst_err} == 6'd0, "R1",
              "outputs after reset", {26'd0, bus_req, busy, done, wb_valid, src_err, dst_err}, 32'd0);

        // R4: plain loop, four 4-byte units
        run_case(32'h0000_1000, 32'h0000_2000, 4, 4, 16, 2, -1, -1, 0, 0, 0, "R4");
        // R4: negative source offset, 2-byte units, slow bus
        run_case(32'h0000_3000, 32'h0000_4000, -2, 8, 6, 1, -1, -1, 0, 2, 0, "R4");
        // R4: count not a multiple of the unit saturates at zero
        run_case(32'h0000_5000, 32'h0000_6000, 4, 4, 5, 2, -1, -1, 0, 0, 0, "R4");
        // R4: zero byte count goes straight to writeback
        run_case(32'h0000_7000, 32'h0000_7800, 1, 1, 0, 0, -1, -1, 0, 0, 0, "R4");
        // R6: read error mid-loop, paired write still runs
        run_case(32'h0000_8000, 32'h0000_9000, 4, 4, 16, 2, 1, -1, 0, 1, 0, "R6");
        // R6: read error on the last unit
        run_case(32'h0000_A000, 32'h0000_B000, 4, -4, 16, 2, 3, -1, 0, 0, 0, "R6");
        // R5: write error with ack also high; error wins, deferred read follows
        run_case(32'h0000_C000, 32'h0000_D000, 8, 8, 16, 3, -1, 0, 1, 0, 0, "R5");
        // R7: write error then deferred read also fails
        run_case(32'h0000_E000, 32'h0000_F000, 1, 1, 8, 0, 3, 2, 0, 0, 0, "R7");
        // R7: write error mid-loop, deferred read succeeds
        run_case(32'h0001_0000, 32'h0001_1000, 2, 2, 8, 1, -1, 1, 0, 1, 0, "R7");
        // R2: stray start while busy is ignored
        run_case(32'h0001_2000, 32'h0001_3000, 4, 4, 16, 2, -1, -1, 0, 2, 1, "R2");
        // R9: clean run after error runs clears the flags
        run_case(32'h0001_4000, 32'h0001_5000, 4, 4, 8, 2, -1, -1, 0, 0, 0, "R4");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule